// File: doc/BRIEF.md
# Breakpoint Acknowledge Cycle Sequencer

This block lives in the execute stage of a small processor core. Every decoded instruction word passes through it. When a word falls in the breakpoint opcode range, the block stalls the pipeline. It then runs one read cycle on the external bus, tagged as an acknowledge transfer, so that debug hardware outside the core can see that a breakpoint was reached. This signal does not depend on where the exception vectors have been relocated.

The acknowledge cycle ends when the bus returns either a normal acknowledge or an error acknowledge. The block then hands over to the exception unit with a request for illegal-instruction processing. Both endings lead to the same exception. A status bit records which way the cycle ended. During the cycle the breakpoint number (0 to 7) is placed on the low address bits, so the external hardware can tell the eight breakpoints apart.

Top module: `brkpt_ack_seq`

## Requirements
- R1: A word is a breakpoint only when `instr_valid` is high and `instr_word` lies in 0x4848..0x484F inclusive. The words 0x4847 and 0x4850 start no bus cycle and raise no stall.
- R2: In the cycle after a breakpoint is detected, `bus_req` is high. During every cycle with `bus_req` high, `bus_rnw` is 1 (read), `bus_tt` is 2'b11 (acknowledge) and `bus_tm` is 3'b000.
- R3: While `bus_req` is high, `bus_addr[2:0]` equals `instr_word[2:0]` of the detected breakpoint and all upper address bits are 0. While idle, `bus_addr` is 0 and `bus_tt` is 2'b00.
- R4: `bus_req` stays high until a clock edge that samples `bus_ta` or `bus_tea` high. It is low from the following cycle on.
- R5: After the acknowledge cycle ends, `exc_req` goes high in the first cycle in which `exc_ready` is high. It stays high for exactly one cycle.
- R6: `bus_err` becomes 1 when `bus_tea` ends the cycle, including when `bus_ta` is high in the same cycle (error wins). It becomes 0 when only `bus_ta` ends the cycle. The exception request is the same in every case.
- R7: `stall` is high in the detection cycle, throughout the bus cycle and the wait for `exc_ready`, and in the `exc_req` cycle. It is low in the cycle after.
- R8: After reset, `bus_req`, `exc_req`, `stall` and `bus_err` are 0.
- R9: A breakpoint word with `instr_valid` low is ignored. Instruction words that arrive while a sequence is in progress are ignored, and the breakpoint number on the bus does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Decoded instruction word is valid |
| instr_word | input | 16 | Decoded instruction word |
| stall | output | 1 | Holds the pipeline |
| bus_req | output | 1 | Acknowledge bus cycle in progress |
| bus_rnw | output | 1 | Read (1) / write (0) |
| bus_tt | output | 2 | Transfer type; 2'b11 is acknowledge |
| bus_tm | output | 3 | Transfer modifier |
| bus_addr | output | 32 | Address; low bits carry the breakpoint number |
| bus_ta | input | 1 | Normal transfer acknowledge |
| bus_tea | input | 1 | Error transfer acknowledge |
| exc_ready | input | 1 | Exception unit can accept a request |
| exc_req | output | 1 | One-cycle illegal-instruction exception request |
| bus_err | output | 1 | Last acknowledge cycle ended with an error |

## Verification
The hardest case to reach from the ports is a set of overlapping conditions: both acknowledge inputs arrive in the same cycle, after the bus has been held for several wait cycles, and the exception unit is not yet ready. The stimulus reaches it by holding the termination for a chosen number of cycles and lowering `exc_ready` before the ending edge. It then checks `bus_err`, the silent `exc_req`, and the held stall on each cycle of the wait. A separate scenario presents another breakpoint word in the middle of a cycle and checks that the address on the bus keeps the first number.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUS  = 2'b01,
        ST_EXC  = 2'b10
    } brk_state_e;

    localparam logic [1:0] TT_NORMAL = 2'b00;
    localparam logic [1:0] TT_ACK    = 2'b11;
    localparam logic [2:0] TM_BRK    = 3'b000;

endpackage

// File: rtl/brk_match.sv
module brk_match #(
    parameter int OPC_W      = 16,
    parameter int CODES_LOG2 = 3,
    parameter logic [OPC_W-1:0] BASE = 16'h4848
) (
    input  logic                  valid,
    input  logic [OPC_W-1:0]      word,
    output logic                  hit,
    output logic [CODES_LOG2-1:0] num
);
    localparam logic [OPC_W-1:0] SPAN = OPC_W'((1 << CODES_LOG2) - 1);
    localparam logic [OPC_W-1:0] LAST = BASE + SPAN;

    logic [OPC_W-1:0] offset;

    always_comb begin
        offset = word - BASE;
        hit    = valid && (word >= BASE) && (word <= LAST);
        num    = offset[CODES_LOG2-1:0];
    end
endmodule

// File: rtl/brk_seq_fsm.sv
module brk_seq_fsm
    import brk_pkg::*;
#(
    parameter int NUM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [NUM_W-1:0] hit_num,
    input  logic             bus_ta,
    input  logic             bus_tea,
    input  logic             exc_ready,
    output brk_state_e       state,
    output logic [NUM_W-1:0] num,
    output logic             err,
    output logic             exc_req,
    output logic             stall
);
    typedef struct packed {
        brk_state_e       st;
        logic [NUM_W-1:0] num;
        logic             err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (hit) begin
                    seq_d.st  = ST_BUS;
                    seq_d.num = hit_num;
                end
            end
            ST_BUS: begin
                if (bus_ta || bus_tea) begin
                    seq_d.st  = ST_EXC;
                    seq_d.err = bus_tea;
                end
            end
            ST_EXC: begin
                if (exc_ready) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, num: '0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        state   = seq_q.st;
        num     = seq_q.num;
        err     = seq_q.err;
        exc_req = (seq_q.st == ST_EXC) && exc_ready;
        stall   = (seq_q.st != ST_IDLE) || hit;
    end

    AST_BUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_BUS && !bus_ta && !bus_tea) |=> (seq_q.st == ST_BUS)) // R4
        else $error("bus cycle left without termination");

    AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_BUS && bus_tea) |=> (seq_q.err && seq_q.st == ST_EXC)) // R6
        else $error("error acknowledge not recorded");

    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req) // R5
        else $error("exception request longer than one cycle");
endmodule

// File: rtl/brk_bus_drive.sv
module brk_bus_drive
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_W  = 3
) (
    input  brk_state_e        state,
    input  logic [NUM_W-1:0]  num,
    output logic              bus_req,
    output logic              bus_rnw,
    output logic [1:0]        bus_tt,
    output logic [2:0]        bus_tm,
    output logic [ADDR_W-1:0] bus_addr
);
    logic [ADDR_W-1:0] addr_full;

    generate
        if (ADDR_W > NUM_W) begin : g_pad
            assign addr_full = {{(ADDR_W-NUM_W){1'b0}}, num};
        end else begin : g_trunc
            assign addr_full = num[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        bus_req  = (state == ST_BUS);
        bus_rnw  = 1'b1;
        bus_tt   = bus_req ? TT_ACK : TT_NORMAL;
        bus_tm   = TM_BRK;
        bus_addr = bus_req ? addr_full : '0;
    end
endmodule

// File: rtl/brkpt_ack_seq.sv
module brkpt_ack_seq
    import brk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OPC_W      = 16,
    parameter int CODES_LOG2 = 3,
    parameter logic [OPC_W-1:0] BRK_BASE = 16'h4848
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [OPC_W-1:0]  instr_word,
    output logic              stall,
    output logic              bus_req,
    output logic              bus_rnw,
    output logic [1:0]        bus_tt,
    output logic [2:0]        bus_tm,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ta,
    input  logic              bus_tea,
    input  logic              exc_ready,
    output logic              exc_req,
    output logic              bus_err
);
    localparam int NUM_W = CODES_LOG2;

    logic             hit_raw;
    logic             hit;
    logic [NUM_W-1:0] hit_num;
    brk_state_e       state;
    logic [NUM_W-1:0] num;

    brk_match #(
        .OPC_W(OPC_W), .CODES_LOG2(CODES_LOG2), .BASE(BRK_BASE)
    ) i_match (
        .valid(instr_valid), .word(instr_word), .hit(hit_raw), .num(hit_num)
    );

    // Detection only counts while no sequence is in progress.
    assign hit = hit_raw && (state == ST_IDLE);

    brk_seq_fsm #(.NUM_W(NUM_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .hit_num(hit_num),
        .bus_ta(bus_ta), .bus_tea(bus_tea), .exc_ready(exc_ready),
        .state(state), .num(num), .err(bus_err),
        .exc_req(exc_req), .stall(stall)
    );

    brk_bus_drive #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) i_drive (
        .state(state), .num(num), .bus_req(bus_req), .bus_rnw(bus_rnw),
        .bus_tt(bus_tt), .bus_tm(bus_tm), .bus_addr(bus_addr)
    );

    AST_ACK_ATTRS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_rnw && bus_tt == TT_ACK && bus_tm == 3'b000)) // R2
        else $error("acknowledge cycle attributes wrong");

    AST_START_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_raw && !stall) |-> 1'b0) // R7
        else $error("breakpoint seen without stall");

    AST_NUM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_addr)) // R9
        else $error("breakpoint number changed mid-cycle");

    AST_NO_REQ_IN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (!bus_req && stall)) // R5
        else $error("exception request during bus cycle");

    AST_BUS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_ta || bus_tea)) |=> !bus_req) // R4
        else $error("bus cycle not ended after acknowledge");
endmodule

// File: tb/test_brkpt_ack_seq.sv
module test_brkpt_ack_seq;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0;
    logic        stall, bus_req, bus_rnw, exc_req, bus_err;
    logic [1:0]  bus_tt;
    logic [2:0]  bus_tm;
    logic [31:0] bus_addr;
    logic        bus_ta = 1'b0, bus_tea = 1'b0, exc_ready = 1'b1;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brkpt_ack_seq i_brkpt_ack_seq (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .stall(stall), .bus_req(bus_req), .bus_rnw(bus_rnw), .bus_tt(bus_tt),
        .bus_tm(bus_tm), .bus_addr(bus_addr), .bus_ta(bus_ta), .bus_tea(bus_tea),
        .exc_ready(exc_ready), .exc_req(exc_req), .bus_err(bus_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R8", "bus_req", 32'(bus_req), 0);
        check("R8", "exc_req", 32'(exc_req), 0);
        check("R8", "stall", 32'(stall), 0);
        check("R8", "bus_err", 32'(bus_err), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_breakpoint(input logic [15:0] op, input logic ta, input logic tea,
                                input int waits, input int ready_lat);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = op;
        #1;
        check("R7", "stall at detect", 32'(stall), 1);
        check("R1", "no bus yet", 32'(bus_req), 0);
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        check("R2", "bus_req", 32'(bus_req), 1);
        check("R2", "bus_rnw", 32'(bus_rnw), 1);
        check("R2", "bus_tt", 32'(bus_tt), 32'h3);
        check("R2", "bus_tm", 32'(bus_tm), 0);
        check("R3", "bus_addr", bus_addr, 32'(op[2:0]));
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            #1;
            check("R4", "bus held", 32'(bus_req), 1);
            check("R7", "stall in bus", 32'(stall), 1);
        end
        exc_ready = (ready_lat == 0);
        bus_ta  = ta;
        bus_tea = tea;
        @(negedge clk);
        bus_ta  = 1'b0;
        bus_tea = 1'b0;
        #1;
        check("R4", "bus ended", 32'(bus_req), 0);
        check("R6", "bus_err", 32'(bus_err), 32'(tea));
        check("R7", "stall after bus", 32'(stall), 1);
        for (int r = 0; r < ready_lat; r++) begin
            check("R5", "no req while not ready", 32'(exc_req), 0);
            check("R7", "stall while waiting", 32'(stall), 1);
            @(negedge clk);
            #1;
        end
        exc_ready = 1'b1;
        #1;
        check("R5", "exc_req", 32'(exc_req), 1);
        check("R7", "stall in req", 32'(stall), 1);
        @(negedge clk);
        #1;
        check("R5", "exc_req one cycle", 32'(exc_req), 0);
        check("R7", "stall released", 32'(stall), 0);
        check("R3", "idle addr", bus_addr, 0);
        check("R3", "idle tt", 32'(bus_tt), 0);
    endtask

    task automatic t_not_breakpoint(input logic [15:0] op, input logic valid);
        @(negedge clk);
        instr_valid = valid;
        instr_word  = op;
        #1;
        check(valid ? "R1" : "R9", "no stall", 32'(stall), 0);
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        check(valid ? "R1" : "R9", "no bus", 32'(bus_req), 0);
        check(valid ? "R1" : "R9", "no exc", 32'(exc_req), 0);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = 16'h4849;
        @(negedge clk);
        instr_word  = 16'h484E;
        #1;
        check("R9", "first number", bus_addr, 32'h1);
        @(negedge clk);
        #1;
        check("R9", "number kept", bus_addr, 32'h1);
        instr_valid = 1'b0;
        bus_ta = 1'b1;
        @(negedge clk);
        bus_ta = 1'b0;
        #1;
        check("R5", "req after busy", 32'(exc_req), 1);
        @(negedge clk);
        #1;
        check("R9", "no second cycle", 32'(bus_req), 0);
        check("R9", "idle after busy", 32'(stall), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_breakpoint(16'h4848, 1'b1, 1'b0, 0, 0);
        t_breakpoint(16'h484F, 1'b0, 1'b1, 2, 0);
        t_breakpoint(16'h484B, 1'b1, 1'b1, 3, 2);
        t_breakpoint(16'h484D, 1'b1, 1'b0, 1, 1);
        t_not_breakpoint(16'h4847, 1'b1);
        t_not_breakpoint(16'h4850, 1'b1);
        t_not_breakpoint(16'h484A, 1'b0);
        t_busy_ignore();
        t_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule